// File: doc/BRIEF.md
# Time-Slotted Shared-Bus Arbiter

This block decides which master owns a shared on-chip bus. It does not arbitrate among the requests that arrive. Software loads a short cyclic slot program into a schedule table, and the arbiter steps through that program on a fixed beat. Each table entry names the master that owns the slot, or marks the slot as unowned. Every slot lasts the same programmable number of cycles. Because the allocation is fixed ahead of time, a master's longest wait for the bus follows directly from the program.

A master receives its grant only while its own slot is current and while it holds its request. Slots that no master uses, either because they are unowned or because the owner is silent, raise an idle flag that a power controller can use to gate the interconnect. Software writes land in a staging copy of the schedule. The running copy takes them over only when the program wraps, so a period that is under way always finishes under the program it began with. The hardware is the two copies of the table, a slot pointer and a cycle counter.

Top module: `tdm_bus_arbiter`

## Requirements
- R1: After reset the running program has one unowned entry that lasts one cycle. `gnt` is all zeros, `idle` is 1 and `cur_slot` is 0, whatever the requests are.
- R2: `gnt[m]` is 1 only when the current entry is owned by master m and `req[m]` is 1 in the same cycle. At most one grant bit is set.
- R3: During an unowned entry (encoding bit ENT_W-1 clear) no grant is given and `idle` is 1, even when every master requests.
- R4: `idle` is 1 exactly in the cycles with no grant. This covers an owned entry whose master is not requesting.
- R5: Each entry stays current for D+1 cycles, where D is the duration field (config address with MSB 1 and low bits 1, data bits DUR_W-1:0).
- R6: `cur_slot` visits the entries 0,1,...,L in order and returns to 0 after entry L, where L is the length field (config address with MSB 1 and low bits 0, data bits SLOT_W-1:0).
- R7: Writes change a staging copy only. The running table, length and duration take the staged values at the last cycle edge of a period, so the period under way keeps the old program.
- R8: The longest wait of a master, counted from raising its request to its grant, equals the largest distance in the program from any cycle to the next cycle that the master owns.
- R9: A config address with MSB 0 writes table entry `cfg_addr[SLOT_W-1:0]`. Its data is `{owned, master index}`, where owned is bit ENT_W-1 and the index is in bits ENT_W-2:0. A write to any other address with MSB 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | SLOT_W+1 | Configuration address (table entry, length or duration) |
| cfg_wdata | input | CFG_DW | Configuration write data |
| req | input | N_MASTERS | Per-master bus request |
| gnt | output | N_MASTERS | Per-master bus grant |
| idle | output | 1 | High when the bus is unused in this cycle |
| cur_slot | output | SLOT_W | Index of the current schedule entry |

## Verification
The bench builds the block with four masters, an eight-entry table and a four-bit duration field. At these sizes a full period is short, so every start phase of every master can be swept when measuring the worst-case wait, and several programs can be changed during a period within a small number of cycles. The single-cycle program left by reset wraps on every cycle. The bench therefore also exercises the staged commit while the schedule is still being loaded, before the real program starts.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

   typedef enum logic [1:0] {
      CFG_NONE  = 2'd0,
      CFG_ENTRY = 2'd1,
      CFG_LEN   = 2'd2,
      CFG_DUR   = 2'd3
   } cfg_kind_e;

   function automatic int unsigned max3(input int unsigned a,
                                        input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/tdm_sched_regs.sv
module tdm_sched_regs
   import tdm_arb_pkg::*;
#(
   parameter int unsigned N_SLOTS = 16,
   parameter int unsigned ENT_W   = 4,
   parameter int unsigned SLOT_W  = 4,
   parameter int unsigned DUR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cfg_kind_e         wr_kind,
   input  logic [SLOT_W-1:0] wr_idx,
   input  logic [ENT_W-1:0]  wr_ent,
   input  logic [SLOT_W-1:0] wr_len,
   input  logic [DUR_W-1:0]  wr_dur,
   input  logic              commit,
   input  logic [SLOT_W-1:0] rd_ptr,
   output logic [ENT_W-1:0]  act_ent,
   output logic [SLOT_W-1:0] act_len,
   output logic [DUR_W-1:0]  act_dur
);

   logic [N_SLOTS-1:0][ENT_W-1:0] stg_tbl;
   logic [N_SLOTS-1:0][ENT_W-1:0] run_tbl;
   logic [SLOT_W-1:0]             stg_len;
   logic [DUR_W-1:0]              stg_dur;

   // staging copy: written by software at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_tbl <= '0;
         stg_len <= '0;
         stg_dur <= '0;
      end else begin
         for (int e = 0; e < int'(N_SLOTS); e++) begin
            if (wr_kind == CFG_ENTRY && wr_idx == SLOT_W'(e))
               stg_tbl[e] <= wr_ent;
         end
         if (wr_kind == CFG_LEN) stg_len <= wr_len;
         if (wr_kind == CFG_DUR) stg_dur <= wr_dur;
      end
   end

   // running copy: refreshed only at the wrap edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_tbl <= '0;
         act_len <= '0;
         act_dur <= '0;
      end else if (commit) begin
         run_tbl <= stg_tbl;
         act_len <= stg_len;
         act_dur <= stg_dur;
      end
   end

   assign act_ent = run_tbl[rd_ptr];

   // R7: the running program is untouched between wrap edges
   a_r7_hold_running: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(run_tbl) && $stable(act_len) && $stable(act_dur)));

   // R7: at a wrap the running program takes the staged one
   a_r7_take_staged: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (act_len == $past(stg_len) && act_dur == $past(stg_dur)));

endmodule

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
   parameter int unsigned SLOT_W = 4,
   parameter int unsigned DUR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] act_len,
   input  logic [DUR_W-1:0]  act_dur,
   output logic [SLOT_W-1:0] ptr,
   output logic              wrap
);

   logic [DUR_W-1:0] beat;
   logic             slot_end;

   assign slot_end = (beat == act_dur);
   assign wrap     = slot_end && (ptr == act_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat <= '0;
         ptr  <= '0;
      end else if (slot_end) begin
         beat <= '0;
         ptr  <= wrap ? '0 : ptr + 1'b1;
      end else begin
         beat <= beat + 1'b1;
      end
   end

   // R5: the pointer holds until the slot's last cycle
   a_r5_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_end |=> (ptr == $past(ptr)));

   // R6: in-period advance by exactly one entry
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && !wrap) |=> (ptr == SLOT_W'($past(ptr) + 1'b1)));

   // R6: return to entry 0 after the last active entry
   a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (ptr == '0 && beat == '0));

   // R6: pointer never passes the active length
   a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= act_len);

endmodule

// File: rtl/tdm_grant_dec.sv
module tdm_grant_dec #(
   parameter int unsigned N_MASTERS = 8,
   parameter int unsigned IDX_W     = 3,
   parameter int unsigned ENT_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ENT_W-1:0]     ent,
   input  logic [N_MASTERS-1:0] req,
   output logic [N_MASTERS-1:0] gnt,
   output logic                 idle
);

   localparam logic [IDX_W:0] NM_C = (IDX_W+1)'(N_MASTERS);

   logic             owned;
   logic [IDX_W-1:0] owner;
   logic             owner_ok;

   assign owned    = ent[ENT_W-1];
   assign owner    = ent[IDX_W-1:0];
   assign owner_ok = owned && ({1'b0, owner} < NM_C);

   // idle derived from the owner's request line, separately from gnt
   assign idle = !(owner_ok && req[owner]);

   for (genvar m = 0; m < int'(N_MASTERS); m++) begin : g_master
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(m);
      assign gnt[m] = owned && (owner == MY_IDX) && req[m];

      // R2: a grant implies the master is requesting
      a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
         gnt[m] |-> req[m]);
   end

   // R2: single owner at a time
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R3: unowned entries hand out nothing
   a_r3_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !owned |-> (gnt == '0 && idle));

   // R4: idle agrees with the grant vector
   a_r4_idle_match: assert property (@(posedge clk) disable iff (!rst_n)
      idle == (gnt == '0));

endmodule

// File: rtl/tdm_bus_arbiter.sv
module tdm_bus_arbiter
   import tdm_arb_pkg::*;
#(
   parameter  int unsigned N_MASTERS = 8,
   parameter  int unsigned N_SLOTS   = 16,
   parameter  int unsigned DUR_W     = 8,
   localparam int unsigned IDX_W     = $clog2(N_MASTERS),
   localparam int unsigned ENT_W     = IDX_W + 1,
   localparam int unsigned SLOT_W    = $clog2(N_SLOTS),
   localparam int unsigned AW        = SLOT_W + 1,
   localparam int unsigned CFG_DW    = max3(ENT_W, SLOT_W, DUR_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [AW-1:0]        cfg_addr,
   input  logic [CFG_DW-1:0]    cfg_wdata,
   input  logic [N_MASTERS-1:0] req,
   output logic [N_MASTERS-1:0] gnt,
   output logic                 idle,
   output logic [SLOT_W-1:0]    cur_slot
);

   // elaboration-time parameter checks
   initial begin
      assert (N_MASTERS >= 2 && N_MASTERS <= 8)
         else $fatal(1, "N_MASTERS must lie in 2..8");
      assert (N_SLOTS >= 2 && N_SLOTS <= 16 && (N_SLOTS & (N_SLOTS - 1)) == 0)
         else $fatal(1, "N_SLOTS must be a power of two in 2..16");
      assert (DUR_W >= 1 && DUR_W <= 16)
         else $fatal(1, "DUR_W must lie in 1..16");
   end

   logic              sel_hi;
   logic [SLOT_W-1:0] sel_lo;
   cfg_kind_e         wr_kind;
   logic [ENT_W-1:0]  act_ent;
   logic [SLOT_W-1:0] act_len;
   logic [DUR_W-1:0]  act_dur;
   logic              wrap;
   logic              unused_cfg;

   assign sel_hi = cfg_addr[SLOT_W];
   assign sel_lo = cfg_addr[SLOT_W-1:0];

   always_comb begin
      if (!cfg_we)                    wr_kind = CFG_NONE;
      else if (!sel_hi)               wr_kind = CFG_ENTRY;
      else if (sel_lo == SLOT_W'(0))  wr_kind = CFG_LEN;
      else if (sel_lo == SLOT_W'(1))  wr_kind = CFG_DUR;
      else                            wr_kind = CFG_NONE;
   end

   assign unused_cfg = ^cfg_wdata;

   tdm_sched_regs #(
      .N_SLOTS (N_SLOTS),
      .ENT_W   (ENT_W),
      .SLOT_W  (SLOT_W),
      .DUR_W   (DUR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_kind (wr_kind),
      .wr_idx  (sel_lo),
      .wr_ent  (cfg_wdata[ENT_W-1:0]),
      .wr_len  (cfg_wdata[SLOT_W-1:0]),
      .wr_dur  (cfg_wdata[DUR_W-1:0]),
      .commit  (wrap),
      .rd_ptr  (cur_slot),
      .act_ent (act_ent),
      .act_len (act_len),
      .act_dur (act_dur)
   );

   tdm_slot_timer #(
      .SLOT_W (SLOT_W),
      .DUR_W  (DUR_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_len (act_len),
      .act_dur (act_dur),
      .ptr     (cur_slot),
      .wrap    (wrap)
   );

   tdm_grant_dec #(
      .N_MASTERS (N_MASTERS),
      .IDX_W     (IDX_W),
      .ENT_W     (ENT_W)
   ) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .ent   (act_ent),
      .req   (req),
      .gnt   (gnt),
      .idle  (idle)
   );

   // R9: a write to an unmapped high address leaves the staged program alone
   a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && sel_hi && sel_lo > SLOT_W'(1)) |-> (wr_kind == CFG_NONE));

endmodule

// File: tb/tdm_bus_arbiter_tb_top.sv
module tdm_bus_arbiter_tb_top;

   localparam int NM = 4;
   localparam int NS = 8;
   localparam int DW = 4;
   localparam int SW = 3;
   localparam int AW = 4;
   localparam int CW = 4;

   // {req[3:0], gnt[3:0], idle} for the 10 cycles of the first program
   localparam logic [8:0] VEC [10] = '{
      {4'b1111, 4'b0001, 1'b0},
      {4'b1110, 4'b0000, 1'b1},
      {4'b0010, 4'b0010, 1'b0},
      {4'b1101, 4'b0000, 1'b1},
      {4'b1111, 4'b0000, 1'b1},
      {4'b0000, 4'b0000, 1'b1},
      {4'b0100, 4'b0100, 1'b0},
      {4'b1111, 4'b0100, 1'b0},
      {4'b1001, 4'b0001, 1'b0},
      {4'b1000, 4'b0000, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_we;
   logic [AW-1:0] cfg_addr;
   logic [CW-1:0] cfg_wdata;
   logic [NM-1:0] req;
   logic [NM-1:0] gnt;
   logic          idle;
   logic [SW-1:0] cur_slot;

   always #5 clk = ~clk;

   tdm_bus_arbiter #(.N_MASTERS(NM), .N_SLOTS(NS), .DUR_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .req(req), .gnt(gnt), .idle(idle),
      .cur_slot(cur_slot)
   );

   int n_chk = 0;
   int n_err = 0;

   // reference program: -1 marks an unowned entry
   int cur_tbl [NS];
   int pend_tbl [NS];
   int cur_len, pend_len, cur_dur, pend_dur, ph;
   logic [NM-1:0] last_gnt;
   logic          last_idle;
   logic [SW-1:0] last_slot;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int period();
      return cur_len * cur_dur;
   endfunction

   function automatic int owner_at(input int p);
      return cur_tbl[p / cur_dur];
   endfunction

   function automatic int bound(input int m);
      int worst = 0;
      for (int s = 0; s < period(); s++) begin
         int d = 0;
         while (owner_at((s + d) % period()) != m) d++;
         if (d > worst) worst = d;
      end
      return worst;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NS; i++) begin
         cur_tbl[i]  = -1;
         pend_tbl[i] = -1;
      end
      cur_len = 1; pend_len = 1; cur_dur = 1; pend_dur = 1; ph = 0;
   endtask

   // one bus cycle: drive requests, sample at negedge, check against the model
   task automatic run_cycle(input logic [NM-1:0] r);
      int own;
      logic [NM-1:0] expg;
      req = r;
      @(negedge clk);
      own  = owner_at(ph);
      expg = (own >= 0 && r[own]) ? NM'(1 << own) : '0;
      last_gnt = gnt; last_idle = idle; last_slot = cur_slot;
      chk(gnt == expg, "R2 grant", int'(gnt), int'(expg));
      chk(idle == (expg == '0), "R4 idle", int'(idle), int'(expg == '0));
      chk(int'(cur_slot) == ph / cur_dur, "R6 slot", int'(cur_slot), ph / cur_dur);
      @(posedge clk);
      if (ph == period() - 1) begin
         ph = 0;
         cur_tbl = pend_tbl; cur_len = pend_len; cur_dur = pend_dur;
      end else begin
         ph++;
      end
      if (cfg_we) begin
         if (!cfg_addr[SW])
            pend_tbl[cfg_addr[SW-1:0]] = cfg_wdata[2] ? int'(cfg_wdata[1:0]) : -1;
         else if (cfg_addr[SW-1:0] == 0)
            pend_len = int'(cfg_wdata[SW-1:0]) + 1;
         else if (cfg_addr[SW-1:0] == 1)
            pend_dur = int'(cfg_wdata[DW-1:0]) + 1;
      end
      #1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d, input logic [NM-1:0] r);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      run_cycle(r);
      cfg_we = 1'b0;
   endtask

   task automatic align(input int target, input logic [NM-1:0] r);
      int guard = 0;
      while (ph != target && guard < 100) begin
         run_cycle(r);
         guard++;
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      int worst, w, m1_cnt;
      model_reset();
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; req = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state with every master requesting
      chk(gnt == '0, "R1 reset gnt", int'(gnt), 0);
      chk(idle == 1'b1, "R1 reset idle", int'(idle), 1);
      chk(cur_slot == '0, "R1 reset slot", int'(cur_slot), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      // R1 R3: default program is a single unowned one-cycle entry
      for (int i = 0; i < 4; i++) begin
         run_cycle('1);
         chk(last_gnt == '0 && last_idle, "R1 default empty", int'(last_gnt), 0);
      end

      // R9: program {m0, m1, empty, m2, m0}, 5 entries, 2 cycles each
      wr(4'd0, 4'd4, '0);
      wr(4'd1, 4'd5, '0);
      wr(4'd2, 4'd0, '0);
      wr(4'd3, 4'd6, '0);
      wr(4'd4, 4'd4, '0);
      wr(4'd8, 4'd4, '0);
      wr(4'd9, 4'd1, '0);
      for (int g = 0; g < 50 && !(cur_len == 5 && cur_dur == 2 && ph == 0); g++)
         run_cycle('0);
      chk(period() == 10, "R7 commit of loaded program", period(), 10);

      // vector table: R2 R3 R4 R5 per cycle
      for (int i = 0; i < 10; i++) begin
         run_cycle(VEC[i][8:5]);
         chk(last_gnt == VEC[i][4:1], "R2 R3 vector grant", int'(last_gnt), int'(VEC[i][4:1]));
         chk(last_idle == VEC[i][0], "R4 vector idle", int'(last_idle), int'(VEC[i][0]));
         chk(int'(last_slot) == i / 2, "R5 vector slot", int'(last_slot), i / 2);
      end

      // R6: mixed request patterns across three periods
      for (int k = 0; k < 30; k++) run_cycle(NM'((k * 5 + 3) % 16));

      // R8: worst wait per master over every start phase
      for (int m = 0; m < 3; m++) begin
         worst = 0;
         for (int s = 0; s < 10; s++) begin
            align(s, '0);
            w = 0;
            run_cycle(NM'(1 << m));
            while (!last_gnt[m] && w < 40) begin
               w++;
               run_cycle(NM'(1 << m));
            end
            if (w > worst) worst = w;
         end
         chk(worst == bound(m), "R8 worst wait", worst, bound(m));
         chk(worst == ((m == 0) ? 6 : 8), "R8 hand bound", worst, (m == 0) ? 6 : 8);
      end

      // R7: mid-period edits to entries 1 and 3 wait for the wrap
      align(3, '1);
      wr(4'd1, 4'd0, '1);
      wr(4'd3, 4'd7, '1);
      align(6, '1);
      run_cycle('1);
      chk(last_gnt == 4'b0100, "R7 old program kept", int'(last_gnt), 4);
      align(2, '1);
      run_cycle('1);
      chk(last_gnt == '0 && last_idle, "R7 new empty entry", int'(last_gnt), 0);
      align(6, '1);
      run_cycle('1);
      chk(last_gnt == 4'b1000, "R7 new owner m3", int'(last_gnt), 8);

      // R5 R6: shrink to 2 entries of 3 cycles
      align(1, '1);
      wr(4'd8, 4'd1, '1);
      wr(4'd9, 4'd2, '1);
      align(0, '1);
      for (int c = 0; c < 12; c++) begin
         run_cycle('1);
         chk(int'(last_slot) == (c % 6) / 3, "R5 three-cycle slot", int'(last_slot), (c % 6) / 3);
      end

      // R9: unmapped address and an inactive entry change nothing visible
      wr(4'd10, 4'd15, '1);
      wr(4'd6, 4'd5, '1);
      align(0, '1);
      m1_cnt = 0;
      for (int c = 0; c < 12; c++) begin
         run_cycle('1);
         if (last_gnt[1]) m1_cnt++;
      end
      chk(m1_cnt == 0, "R9 ignored writes", m1_cnt, 0);
      chk(period() == 6, "R9 program unchanged", period(), 6);

      report();
      $finish;
   end

endmodule